// File: doc/BRIEF.md
# Burst Address Stepper

This block works out the address sequence of a pipelined bus burst. A bus manager uses it to issue the beats of a burst, and a subordinate uses it to follow them. The owner pulses `start` with the first address, the burst kind and the transfer size. From then on it pulses `beat_done` each time a beat completes. The block holds the current beat address. It also presents, with no added delay, the address the next completed beat will move to.

Incrementing bursts step by the transfer size, which is one byte shifted left by the size code. Wrapping bursts form the sum the same way. They then keep only the bits below the wrap boundary, which is beats times transfer size, and take the bits above it from the current address. When the low part overflows, the sequence returns to the start of the aligned block, with no divide and no extra cycle. A down-counter holds the beats still to come and raises a last-beat flag for bursts of known length.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `cur_addr` is 0, `beats_left` is 0 and `last_beat` is 0. The stored burst kind is the open-ended increment.
- R2: When `start` is sampled high, the edge loads `first_addr` into `cur_addr` and loads the burst kind and size. `start` takes priority over `beat_done` in the same cycle.
- R3: For incrementing bursts (kind codes 0, 1, 3, 5, 7), each `beat_done` edge without `start` adds `1 << size` to `cur_addr`, modulo 2^ADDR_W.
- R4: For wrapping bursts (kind codes 2, 4, 6), each completed beat adds `1 << size` to the bits below the boundary `beats << size` only. Those bits roll over to zero. The bits at and above the boundary stay unchanged.
- R5: Kind codes: 0 is single (1 beat) and 1 is open-ended increment. 2, 4 and 6 wrap over 4, 8 and 16 beats. 3, 5 and 7 increment over 4, 8 and 16 beats. After `start`, `beats_left` equals beats minus one, and is 0 for codes 0 and 1.
- R6: `next_addr` always equals the value that `cur_addr` will take on the next `beat_done` edge without `start`, in the same cycle.
- R7: Each `beat_done` edge without `start` lowers a nonzero `beats_left` by one. `last_beat` is high exactly when `beats_left` is 0 and the kind is not 1. So a single burst is last at once, and an open-ended increment is never flagged last.
- R8: In a cycle with neither `start` nor `beat_done`, `cur_addr`, `beats_left` and `last_beat` hold their values.
- R9: A `beat_done` edge with `beats_left` at 0 leaves it at 0. The address still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| start | input | 1 | Begin a new burst with the values below |
| first_addr | input | ADDR_W | Address of the first beat |
| burst_kind | input | 3 | Burst kind code (R5) |
| xfer_size | input | 3 | Transfer size code; bytes per beat are 1 << code |
| beat_done | input | 1 | Current beat completed; advance address and count |
| cur_addr | output | ADDR_W | Address of the current beat (registered) |
| next_addr | output | ADDR_W | Address of the following beat (combinational) |
| beats_left | output | CNT_W | Beats remaining after the current one |
| last_beat | output | 1 | Current beat ends a burst of known length |

## Verification
`next_addr` is combinational from stored state, so it is compared in the same cycle. The bench waits a short settle delay after it drives the inputs, and before the next rising edge. `cur_addr`, `beats_left` and `last_beat` change one edge after `start` or `beat_done`, so the bench reads them at the falling edge that follows. The reference model updates at that rising edge and is compared every cycle. The address sequences come from modulo arithmetic on the aligned block base, which is a different method from the masked increment in the RTL.

// File: rtl/burst_agu_pkg.sv
package burst_agu_pkg;

  typedef enum logic [2:0] {
    BK_ONE    = 3'd0,
    BK_OPEN   = 3'd1,
    BK_WRAP4  = 3'd2,
    BK_STEP4  = 3'd3,
    BK_WRAP8  = 3'd4,
    BK_STEP8  = 3'd5,
    BK_WRAP16 = 3'd6,
    BK_STEP16 = 3'd7
  } burst_kind_e;

  localparam int unsigned KIND_W = 3;
  localparam int unsigned SIZE_W = 3;

endpackage

// File: rtl/burst_kind_decode.sv
module burst_kind_decode
  import burst_agu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 4
) (
  input  burst_kind_e             kind,
  input  logic [SIZE_W-1:0]       size,
  output logic [CNT_W-1:0]        beats_m1,
  output logic                    is_wrap,
  output logic                    is_fixed,
  output logic [ADDR_W-1:0]       step,
  output logic [ADDR_W-1:0]       low_mask
);

  localparam logic [ADDR_W-1:0] ONE_A = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] beats_a;
  logic [ADDR_W-1:0] boundary;

  always_comb begin
    unique case (kind)
      BK_WRAP4, BK_STEP4:   beats_m1 = CNT_W'(3);
      BK_WRAP8, BK_STEP8:   beats_m1 = CNT_W'(7);
      BK_WRAP16, BK_STEP16: beats_m1 = CNT_W'(15);
      default:              beats_m1 = '0;
    endcase
  end

  assign is_wrap  = (kind == BK_WRAP4) || (kind == BK_WRAP8) || (kind == BK_WRAP16);
  assign is_fixed = (kind != BK_OPEN);
  assign step     = ONE_A << size;
  assign beats_a  = {{(ADDR_W-CNT_W){1'b0}}, beats_m1} + ONE_A;
  assign boundary = beats_a << size;
  // Incrementing kinds let every bit carry; wrapping kinds confine the carry.
  assign low_mask = is_wrap ? (boundary - ONE_A) : '1;

endmodule

// File: rtl/addr_stepper.sv
module addr_stepper #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [ADDR_W-1:0] step,
  input  logic [ADDR_W-1:0] low_mask,
  output logic [ADDR_W-1:0] nxt
);

  logic [ADDR_W-1:0] sum;

  assign sum = cur + step;
  assign nxt = (cur & ~low_mask) | (sum & low_mask);

endmodule

// File: rtl/beat_counter.sv
module beat_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (load) begin
      cnt_d = load_val;
    end else if (dec && (cnt != '0)) begin
      cnt_d = cnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load || dec) begin
      cnt <= cnt_d;
    end
  end

  AST_CNT_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && cnt != '0) |=> cnt == $past(cnt) - CNT_W'(1)); // R7
  AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && cnt == '0) |=> cnt == '0); // R9

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_agu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] first_addr,
  input  logic [2:0]        burst_kind,
  input  logic [2:0]        xfer_size,
  input  logic              beat_done,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] next_addr,
  output logic [CNT_W-1:0]  beats_left,
  output logic              last_beat
);

  burst_kind_e       kind_q, kind_d, kind_in;
  logic [SIZE_W-1:0] size_q, size_d;
  logic [ADDR_W-1:0] addr_q, addr_d;

  logic [CNT_W-1:0]  cur_m1, in_m1;
  logic              cur_wrap, cur_fixed, in_wrap, in_fixed;
  logic [ADDR_W-1:0] cur_step, cur_mask, in_step, in_mask;
  logic [ADDR_W-1:0] stepped;
  logic              advance;

  assign kind_in = burst_kind_e'(burst_kind);
  assign advance = beat_done && !start;

  burst_kind_decode #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dec_cur (
    .kind(kind_q), .size(size_q), .beats_m1(cur_m1), .is_wrap(cur_wrap),
    .is_fixed(cur_fixed), .step(cur_step), .low_mask(cur_mask)
  );

  burst_kind_decode #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dec_in (
    .kind(kind_in), .size(xfer_size), .beats_m1(in_m1), .is_wrap(in_wrap),
    .is_fixed(in_fixed), .step(in_step), .low_mask(in_mask)
  );

  addr_stepper #(.ADDR_W(ADDR_W)) u_step (
    .cur(addr_q), .step(cur_step), .low_mask(cur_mask), .nxt(stepped)
  );

  beat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(start), .load_val(in_m1),
    .dec(advance), .cnt(beats_left)
  );

  always_comb begin
    kind_d = kind_q;
    size_d = size_q;
    addr_d = addr_q;
    if (start) begin
      kind_d = kind_in;
      size_d = xfer_size;
      addr_d = first_addr;
    end else if (beat_done) begin
      addr_d = stepped;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= BK_OPEN;
      size_q <= '0;
      addr_q <= '0;
    end else if (start || beat_done) begin
      kind_q <= kind_d;
      size_q <= size_d;
      addr_q <= addr_d;
    end
  end

  assign cur_addr  = addr_q;
  assign next_addr = stepped;
  assign last_beat = cur_fixed && (beats_left == '0);

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> addr_q == $past(first_addr)); // R2
  AST_INCR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !cur_wrap) |=> addr_q == $past(addr_q) + $past(cur_step)); // R3
  AST_WRAP_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && cur_wrap) |=> (addr_q & ~$past(cur_mask)) == ($past(addr_q) & ~$past(cur_mask))); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !beat_done) |=> ($stable(addr_q) && $stable(beats_left) && $stable(last_beat))); // R8
  AST_OPEN_NEVER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == BK_OPEN) |-> !last_beat); // R7

endmodule

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] first_addr = '0;
  logic [2:0]  burst_kind = '0;
  logic [2:0]  xfer_size = '0;
  logic        beat_done = 1'b0;
  logic [31:0] cur_addr, next_addr;
  logic [3:0]  beats_left;
  logic        last_beat;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_addr = '0;
  int          m_kind = 1;
  int          m_size = 0;
  int          m_left = 0;

  always #(CLK_P/2) clk = ~clk;

  burst_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .start(start), .first_addr(first_addr),
    .burst_kind(burst_kind), .xfer_size(xfer_size), .beat_done(beat_done),
    .cur_addr(cur_addr), .next_addr(next_addr), .beats_left(beats_left),
    .last_beat(last_beat)
  );

  function automatic int beats_of(int k);
    case (k)
      2, 3: return 4;
      4, 5: return 8;
      6, 7: return 16;
      default: return 1;
    endcase
  endfunction

  function automatic logic [31:0] model_next();
    logic [31:0] stp, blk, base;
    stp = 32'd1 << m_size;
    if (m_kind == 2 || m_kind == 4 || m_kind == 6) begin
      blk  = 32'(beats_of(m_kind)) * stp;
      base = m_addr - (m_addr % blk);
      return base + ((m_addr - base + stp) % blk);
    end
    return m_addr + stp;
  endfunction

  task automatic check32(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_regs(string req);
    check32(req, "cur_addr", cur_addr, m_addr);
    check32(req, "beats_left", {28'd0, beats_left}, 32'(m_left));
    check32(req, "last_beat", {31'd0, last_beat}, {31'd0, (m_kind != 1) && (m_left == 0)});
  endtask

  // One cycle: drive at negedge, check comb output, let the edge pass, check registers.
  task automatic cyc(string req, bit st, logic [31:0] fa, int k, int sz, bit bd);
    start = st; first_addr = fa; burst_kind = 3'(k); xfer_size = 3'(sz); beat_done = bd;
    #1;
    check32(req, "next_addr", next_addr, model_next());
    @(posedge clk);
    if (st) begin
      m_addr = fa; m_kind = k; m_size = sz; m_left = beats_of(k) - 1;
    end else if (bd) begin
      m_addr = model_next();
      if (m_left > 0) m_left--;
    end
    @(negedge clk);
    check_regs(req);
  endtask

  task automatic run_burst(string req, logic [31:0] fa, int k, int sz, int nbeats);
    cyc(req, 1'b1, fa, k, sz, 1'b0);
    for (int i = 0; i < nbeats; i++) cyc(req, 1'b0, 32'h0, 0, 0, 1'b1);
  endtask

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check_regs("R1");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_regs("R1");

    run_burst("R3", 32'h0000_0100, 3, 2, 3);           // four-beat increment, words
    run_burst("R4", 32'h0000_0038, 2, 2, 5);           // 38 3C 30 34 38 ...
    run_burst("R4", 32'h0000_001E, 4, 1, 9);           // halfword wrap over 16 bytes
    run_burst("R4", 32'h0000_007C, 6, 2, 17);          // word wrap over 64 bytes
    run_burst("R4", 32'hFFFF_FFF8, 2, 2, 4);           // upper bits stay all ones
    run_burst("R5", 32'h0000_0203, 5, 0, 8);           // eight-beat byte increment
    run_burst("R5", 32'h0000_4000, 7, 3, 16);          // sixteen-beat doubleword
    run_burst("R7", 32'h0000_0500, 1, 2, 6);           // open-ended, never last
    run_burst("R7", 32'h0000_0600, 0, 2, 0);           // single, last at once
    run_burst("R3", 32'hFFFF_FFFC, 1, 2, 2);           // carry past the top
    run_burst("R4", 32'h0000_0FC0, 6, 7, 3);           // large size wrap

    // R8: idle cycles hold state mid-burst.
    cyc("R2", 1'b1, 32'h0000_0904, 4, 2, 1'b0);
    cyc("R8", 1'b0, 32'h0, 0, 0, 1'b1);
    for (int i = 0; i < 3; i++) cyc("R8", 1'b0, 32'h1234_5678, 3, 1, 1'b0);
    cyc("R6", 1'b0, 32'h0, 0, 0, 1'b1);

    // R2: start wins over a simultaneous beat_done.
    cyc("R2", 1'b1, 32'h0000_0A10, 2, 1, 1'b1);
    cyc("R2", 1'b1, 32'h0000_0B00, 7, 0, 1'b1);

    // R9: extra beats past the end keep the count at zero.
    run_burst("R9", 32'h0000_0C00, 3, 0, 7);
    run_burst("R9", 32'h0000_0C30, 2, 2, 6);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule